// File: doc/BRIEF.md
# Two-Wire Write-Only DAC Code Controller

This block is the digital front end of a 10-bit current DAC. It listens to a two-wire serial bus as a receive-only slave. It oversamples SCL and SDA with the system clock and decodes START and STOP conditions. When a write transaction carries one of its four addresses, it acknowledges by pulling SDA low. It then takes a command byte, which holds a shutdown request and the two top code bits, and a data byte, which holds the eight low code bits.

The code is committed in two steps. The command fields go into a staging register when the command acknowledge ends. The full code moves to the output register only when the data acknowledge ends. A STOP that comes before that point leaves the output unchanged. Two strap pins select the address and also the power-up code. The DAC is held off while the active-low sleep pin is low or while the staged shutdown bit is set. The code itself is kept through shutdown.

Top module: `dac_ctl_slave`

## Requirements
- R1: The slave address is the 7 bits 01011 followed by two strap-selected bits: {strap_a1,strap_a0} = 00 gives low bits 01, 01 gives 11, 10 gives 10, 11 gives 00. After an address byte that matches, followed by write bit 0 (address in bits 7..1, direction in bit 0, MSB first), the slave drives sda_oe high during the ninth SCL pulse. sda_oe only goes high after a falling SCL edge.
- R2: If the address does not match, or the direction bit is 1, the slave gives no acknowledge. It acknowledges nothing else and leaves dac_code unchanged until the next START.
- R3: In the command byte, bit 7 is the shutdown request and bits 1..0 become code bits 9..8. Bits 6..2 have no effect. The slave acknowledges the command byte.
- R4: The data byte, sent MSB first, supplies code bits 7..0. dac_code takes the new 10-bit value only after the falling SCL edge that ends the data acknowledge. It does not change at the command acknowledge, and it does not change during the high phase of the data acknowledge.
- R5: A STOP is accepted at any bit position. It releases SDA. If it comes before the data acknowledge ends, dac_code keeps its old value.
- R6: While reset is applied, dac_code takes 1000000000 when both straps are high and 0000000000 otherwise. dac_off is 0 when sleep_n is high.
- R7: dac_off is 1 whenever sleep_n is low or the staged shutdown bit is 1. The staged bit changes at the end of the command acknowledge. dac_code keeps its value through shutdown.
- R8: SDA is only ever pulled low, through sda_oe. The acknowledge is released after the falling SCL edge that ends the acknowledge bit, and sda_oe is 0 again within a quarter SCL period.
- R9: A repeated START, at any point, restarts address reception. A transaction that follows it completes normally.
- R10: Bytes that follow the data byte in the same transaction are not acknowledged and do not change dac_code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_i | input | 1 | Bus clock line, asynchronous |
| sda_i | input | 1 | Bus data line as seen on the wire, asynchronous |
| sda_oe | output | 1 | When 1, pulls the data line low |
| strap_a1 | input | 1 | Upper address strap |
| strap_a0 | input | 1 | Lower address strap |
| sleep_n | input | 1 | Active-low shutdown pin |
| dac_code | output | CODE_W | Committed DAC code |
| dac_off | output | 1 | DAC shutdown request |

## Verification
The bench sweeps all four strap settings against every address low-bit pattern with both directions. This catches a swapped strap map, an acknowledge given to reads, and a write that leaks through after a rejected address. A sweep of 64 codes with varying don't-care command bits compares the code at the command acknowledge, during the data acknowledge and after it. A design that commits early, or that lets bits 6..2 leak into the code, fails there. STOPs are issued inside the address, after the command byte and inside the data byte. An output that moves on a partial write is caught, and so is one that fails to recover. Repeated STARTs, trailing bytes and both shutdown sources are also checked, to catch lost staging and a code wiped by shutdown.

// File: rtl/dacs_pkg.sv
package dacs_pkg;
  localparam logic [4:0] ADDR_PREFIX = 5'b01011;

  typedef enum logic [2:0] {
    PH_IDLE, PH_ADDR, PH_ACKA, PH_CMD, PH_ACKC, PH_DATA, PH_ACKD
  } phase_e;

  // strap pair -> 7-bit bus address
  function automatic logic [6:0] strap_addr(input logic a1, input logic a0);
    return {ADDR_PREFIX, a1 ^ a0, ~a1};
  endfunction
endpackage

// File: rtl/dacs_sync.sv
module dacs_sync #(
  parameter int W      = 2,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] chain [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (!rst_n) chain[g] <= '1;
        else        chain[g] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (!rst_n) chain[g] <= '1;
        else        chain[g] <= chain[g-1];
      end
    end
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/dacs_linecond.sv
module dacs_linecond (
  input  logic clk,
  input  logic rst_n,
  input  logic scl,
  input  logic sda,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic scl_q, sda_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl;
      sda_q <= sda;
    end
  end

  assign scl_rise  = scl & ~scl_q;
  assign scl_fall  = ~scl & scl_q;
  assign start_det = scl & scl_q & sda_q & ~sda;
  assign stop_det  = scl & scl_q & ~sda_q & sda;
endmodule

// File: rtl/dacs_wproto.sv
module dacs_wproto
  import dacs_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_rise,
  input  logic       scl_fall,
  input  logic       start_det,
  input  logic       stop_det,
  input  logic       sda_bit,
  input  logic [6:0] my_addr,
  output logic       sda_oe,
  output logic       cmd_take,
  output logic       data_take,
  output logic [7:0] rx_byte
);
  phase_e     ph;
  logic [3:0] bit_cnt;
  logic       oe_q;

  wire in_byte  = (ph == PH_ADDR) || (ph == PH_CMD) || (ph == PH_DATA);
  wire in_ack   = (ph == PH_ACKA) || (ph == PH_ACKC) || (ph == PH_ACKD);
  wire byte_end = in_byte && scl_fall && (bit_cnt == 4'd8);
  wire ack_end  = in_ack && scl_fall;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ph      <= PH_IDLE;
      bit_cnt <= '0;
      rx_byte <= '0;
      oe_q    <= 1'b0;
    end else if (start_det) begin
      ph      <= PH_ADDR;
      bit_cnt <= '0;
      oe_q    <= 1'b0;
    end else if (stop_det) begin
      ph      <= PH_IDLE;
      oe_q    <= 1'b0;
    end else begin
      if (in_byte && scl_rise && (bit_cnt != 4'd8)) begin
        rx_byte <= {rx_byte[6:0], sda_bit};
        bit_cnt <= bit_cnt + 4'd1;
      end
      if (byte_end) begin
        unique case (ph)
          PH_ADDR: begin
            if (rx_byte == {my_addr, 1'b0}) begin
              ph   <= PH_ACKA;
              oe_q <= 1'b1;
            end else begin
              ph   <= PH_IDLE;
            end
          end
          PH_CMD:  begin ph <= PH_ACKC; oe_q <= 1'b1; end
          default: begin ph <= PH_ACKD; oe_q <= 1'b1; end
        endcase
      end
      if (ack_end) begin
        oe_q    <= 1'b0;
        bit_cnt <= '0;
        unique case (ph)
          PH_ACKA: ph <= PH_CMD;
          PH_ACKC: ph <= PH_DATA;
          default: ph <= PH_IDLE;
        endcase
      end
    end
  end

  assign sda_oe    = oe_q;
  assign cmd_take  = ack_end && (ph == PH_ACKC) && !start_det && !stop_det;
  assign data_take = ack_end && (ph == PH_ACKD) && !start_det && !stop_det;
endmodule

// File: rtl/dacs_coderegs.sv
module dacs_coderegs #(
  parameter int CODE_W = 10,
  localparam int HI_W  = CODE_W - 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mid_reset,
  input  logic              cmd_take,
  input  logic              cmd_sd,
  input  logic [HI_W-1:0]   cmd_hi,
  input  logic              data_take,
  input  logic [7:0]        data_lo,
  output logic              stage_sd,
  output logic [CODE_W-1:0] code
);
  logic [HI_W-1:0] stage_hi;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stage_sd <= 1'b0;
      stage_hi <= '0;
    end else if (cmd_take) begin
      stage_sd <= cmd_sd;
      stage_hi <= cmd_hi;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)         code <= {mid_reset, {(CODE_W-1){1'b0}}};
    else if (data_take) code <= {stage_hi, data_lo};
  end
endmodule

// File: rtl/dac_ctl_slave.sv
module dac_ctl_slave
  import dacs_pkg::*;
#(
  parameter int CODE_W      = 10,
  parameter int SYNC_STAGES = 2,
  localparam int HI_W       = CODE_W - 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe,
  input  logic              strap_a1,
  input  logic              strap_a0,
  input  logic              sleep_n,
  output logic [CODE_W-1:0] dac_code,
  output logic              dac_off
);
  logic       scl_s, sda_s;
  logic       scl_rise, scl_fall, start_det, stop_det;
  logic       cmd_take, data_take, stage_sd;
  logic [7:0] rx_byte;

  dacs_sync #(.W(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d({scl_i, sda_i}), .q({scl_s, sda_s})
  );

  dacs_linecond u_cond (
    .clk(clk), .rst_n(rst_n), .scl(scl_s), .sda(sda_s),
    .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det)
  );

  dacs_wproto u_proto (
    .clk(clk), .rst_n(rst_n), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det), .sda_bit(sda_s),
    .my_addr(strap_addr(strap_a1, strap_a0)), .sda_oe(sda_oe),
    .cmd_take(cmd_take), .data_take(data_take), .rx_byte(rx_byte)
  );

  dacs_coderegs #(.CODE_W(CODE_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .mid_reset(strap_a1 & strap_a0),
    .cmd_take(cmd_take), .cmd_sd(rx_byte[7]), .cmd_hi(rx_byte[HI_W-1:0]),
    .data_take(data_take), .data_lo(rx_byte), .stage_sd(stage_sd),
    .code(dac_code)
  );

  assign dac_off = ~sleep_n | stage_sd;
endmodule

// File: rtl/dacs_chk.sv
module dacs_chk #(
  parameter int CODE_W = 10
) (
  input logic              clk,
  input logic              rst_n,
  input logic              scl_fall,
  input logic              start_det,
  input logic              stop_det,
  input logic              data_take,
  input logic              sda_oe,
  input logic              strap_a1,
  input logic              strap_a0,
  input logic [CODE_W-1:0] dac_code
);
  // R1: acknowledge drive begins only after a falling SCL edge
  assert_ack_on_fall_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe) |-> $past(scl_fall));

  // R4: the code moves only on a data-acknowledge commit
  assert_code_commit_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (dac_code != $past(dac_code)) |-> $past(data_take));

  // R5: STOP frees the data line
  assert_stop_release_R5: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> !sda_oe);

  // R6: code leaving reset follows the straps
  assert_reset_code_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(rst_n) |-> (dac_code == {strap_a1 & strap_a0, {(CODE_W-1){1'b0}}}));

  // R8: release only at SCL fall or a bus condition
  assert_ack_release_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sda_oe) |-> $past(scl_fall || start_det || stop_det));
endmodule

bind dac_ctl_slave dacs_chk #(.CODE_W(CODE_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .scl_fall(scl_fall), .start_det(start_det),
  .stop_det(stop_det), .data_take(data_take), .sda_oe(sda_oe),
  .strap_a1(strap_a1), .strap_a0(strap_a0), .dac_code(dac_code)
);

// File: tb/tb_dac_ctl_slave.sv
module tb_dac_ctl_slave;
  localparam int CLK_PERIOD = 10;
  localparam int QTR        = 6;
  localparam int CW         = 10;
  localparam int WATCHDOG   = 190000;

  logic clk = 1'b0, rst_n = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1;
  logic strap_a1 = 1'b0, strap_a0 = 1'b0, sleep_n = 1'b1;
  logic sda_oe, dac_off;
  logic [CW-1:0] dac_code;
  wire  sda_line = sda_m & ~sda_oe;

  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dac_ctl_slave dut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line),
    .sda_oe(sda_oe), .strap_a1(strap_a1), .strap_a0(strap_a0),
    .sleep_n(sleep_n), .dac_code(dac_code), .dac_off(dac_off)
  );

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic q(); repeat (QTR) @(negedge clk); endtask

  function automatic int exp_lo(int s);
    case (s)
      0: return 1;
      1: return 3;
      2: return 2;
      default: return 0;
    endcase
  endfunction

  task automatic do_reset(int s);
    @(negedge clk);
    rst_n = 1'b0; strap_a1 = s[1]; strap_a0 = s[0];
    scl_m = 1'b1; sda_m = 1'b1;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    q();
  endtask

  task automatic bus_start();
    sda_m = 1'b1; q(); scl_m = 1'b1; q(); sda_m = 1'b0; q(); scl_m = 1'b0; q();
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; q(); scl_m = 1'b1; q(); sda_m = 1'b1; q(); q();
  endtask

  task automatic send_bits(logic [7:0] b, int n);
    for (int i = 0; i < n; i++) begin
      sda_m = b[7-i]; q(); scl_m = 1'b1; q(); q(); scl_m = 1'b0; q();
    end
  endtask

  // ninth clock: returns ack and the code seen mid-high; checks release (R8)
  task automatic byte_ack(logic [7:0] b, output int ak, output int cm);
    send_bits(b, 8);
    sda_m = 1'b1; q(); scl_m = 1'b1; q();
    ak = sda_oe; cm = dac_code;
    q(); scl_m = 1'b0; q();
    chk("R8", sda_oe, 0);
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual running expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    int ak, cm, cur, v, hit;
    // strap and address sweep
    for (int s = 0; s < 4; s++) begin
      do_reset(s);
      cur = (s == 3) ? 512 : 0;
      chk("R6", dac_code, cur);
      chk("R6", dac_off, 0);
      chk("R8", sda_oe, 0);
      for (int lo = 0; lo < 4; lo++) begin
        for (int rw = 0; rw < 2; rw++) begin
          v   = ((s*8 + lo*2 + rw) * 29 + 7) % 1024;
          hit = (lo == exp_lo(s) && rw == 0) ? 1 : 0;
          bus_start();
          byte_ack({5'b01011, lo[1:0], rw[0]}, ak, cm);
          chk(hit ? "R1" : "R2", ak, hit);
          byte_ack({6'b0, v[9:8]}, ak, cm);
          chk(hit ? "R3" : "R2", ak, hit);
          byte_ack(v[7:0], ak, cm);
          chk(hit ? "R4" : "R2", ak, hit);
          chk("R4", cm, cur);
          if (hit == 1) cur = v;
          chk(hit ? "R4" : "R2", dac_code, cur);
          bus_stop();
        end
      end
    end

    // code sweep with varying don't-care command bits, straps LH
    do_reset(1);
    cur = 0;
    for (int k = 0; k < 64; k++) begin
      v = (k * 331 + 5) % 1024;
      bus_start();
      byte_ack(8'b0101_1110, ak, cm);
      byte_ack({1'b0, k[4:0], v[9:8]}, ak, cm);
      chk("R3", ak, 1);
      chk("R4", dac_code, cur);
      byte_ack(v[7:0], ak, cm);
      chk("R4", cm, cur);
      chk("R4", dac_code, v);
      chk("R3", dac_off, 0);
      cur = v;
      if (k[0]) bus_stop();
    end
    bus_stop();

    // shutdown via command bit and via pin
    bus_start();
    byte_ack(8'b0101_1110, ak, cm);
    byte_ack(8'b1000_0001, ak, cm);
    chk("R7", dac_off, 1);
    chk("R7", dac_code, cur);
    byte_ack(8'h55, ak, cm);
    chk("R7", dac_code, 341);
    chk("R7", dac_off, 1);
    bus_stop();
    bus_start();
    byte_ack(8'b0101_1110, ak, cm);
    byte_ack(8'b0000_0001, ak, cm);
    byte_ack(8'h55, ak, cm);
    bus_stop();
    chk("R7", dac_off, 0);
    chk("R7", dac_code, 341);
    sleep_n = 1'b0; q();
    chk("R7", dac_off, 1);
    chk("R7", dac_code, 341);
    sleep_n = 1'b1; q();
    chk("R7", dac_off, 0);
    cur = 341;

    // early STOPs
    bus_start();
    byte_ack(8'b0101_1110, ak, cm);
    byte_ack(8'b0000_0010, ak, cm);
    bus_stop();
    chk("R5", dac_code, cur);
    chk("R5", sda_oe, 0);
    bus_start();
    send_bits(8'b0101_1110, 3);
    bus_stop();
    chk("R5", sda_oe, 0);
    chk("R5", dac_code, cur);
    bus_start();
    byte_ack(8'b0101_1110, ak, cm);
    chk("R5", ak, 1);
    byte_ack(8'b0000_0011, ak, cm);
    send_bits(8'h0F, 4);
    bus_stop();
    chk("R5", dac_code, cur);
    bus_start();
    byte_ack(8'b0101_1110, ak, cm);
    byte_ack(8'b0000_0010, ak, cm);
    byte_ack(8'hA5, ak, cm);
    bus_stop();
    cur = 512 + 165;
    chk("R5", dac_code, cur);

    // repeated START mid-command and after a rejected address
    bus_start();
    byte_ack(8'b0101_1110, ak, cm);
    send_bits(8'b0000_0011, 5);
    bus_start();
    byte_ack(8'b0101_1110, ak, cm);
    chk("R9", ak, 1);
    byte_ack(8'b0000_0001, ak, cm);
    byte_ack(8'h3C, ak, cm);
    cur = 256 + 60;
    chk("R9", dac_code, cur);
    bus_start();
    byte_ack(8'b0101_1100, ak, cm);
    chk("R9", ak, 0);
    bus_start();
    byte_ack(8'b0101_1110, ak, cm);
    chk("R9", ak, 1);
    byte_ack(8'b0000_0000, ak, cm);
    byte_ack(8'h99, ak, cm);
    cur = 153;
    chk("R9", dac_code, cur);

    // trailing byte after the data byte
    byte_ack(8'hFF, ak, cm);
    chk("R10", ak, 0);
    chk("R10", dac_code, cur);
    bus_stop();
    chk("R10", dac_code, cur);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule